// File: doc/BRIEF.md
# Instruction Phase Sequencer

This block sequences a small accumulator machine through its fetch, indirect and execute phases. Each advance moves the machine by exactly one phase. A phase advances when the machine is in run mode, or when a single-step pulse arrives. The block holds the program counter, the memory address register, the instruction register and two accumulators, A and B. It drives one memory port, whose read data must be valid in the same cycle as the address it is given.

The block decodes load, add and store for either accumulator, an unconditional jump, a jump to subroutine, halt and no-operation. It forms addresses from a 10-bit offset plus a page selector bit. That bit picks either page zero or the page of the instruction's own address. Indirect words may chain across any number of levels.

A subroutine call writes the return address into its target word and resumes one word past the target. A return is an indirect jump through that target word.

Top module: `phase_seq`

## Requirements
- R1: After reset the block is in fetch phase, the program counter and memory address equal RESET_PC, both accumulators are zero, halt_o is low and nothing advances.
- R2: A phase advances only in a cycle where step_i is high or run mode is set. Otherwise the program counter, the memory address, the phase and the accumulators hold.
- R3: A decoded memory-reference instruction with bit 15 set moves from fetch to indirect phase, and indirect_o is asserted.
- R4: In indirect phase the read word's bits 14..0 become the memory address. If the word's bit 15 is 1, the block stays in indirect phase. If it is 0, a jump completes, and any other instruction goes to execute phase with execute_o asserted.
- R5: The effective address is bits 9..0 of the instruction. Its upper five bits are zero when instruction bit 10 is 0, and are the page bits of the instruction's own address when bit 10 is 1.
- R6: Bits 14..11 decode as follows. 1100 and 1101 are load. 1000 and 1001 are add (two's complement, wrapping at 16 bits). 1110 and 1111 are store. Bit 11 selects A (0) or B (1). A store writes the chosen accumulator.
- R7: Every instruction that is not a jump, including no-operation (word 000000 octal), leaves the program counter and memory address at the instruction address plus one when it completes.
- R8: Bits 14..11 = 0101 is a jump. Without bit 15 it completes in its fetch phase, setting the program counter and memory address to the effective address.
- R9: Bits 14..11 = 0011 is jump to subroutine. Its first phase addresses the target and leaves the program counter unchanged. Its execute phase writes the program counter plus one to the target, then sets the program counter and memory address to the target plus one.
- R10: An indirect jump loads the program counter with bits 14..0 of the final address word it reads.
- R11: Word 102000 octal is halt. It advances the program counter by one, sets halt_o and leaves run mode. start_i sets run mode and clears halt_o, and step_i also clears halt_o.
- R12: mem_addr_o always equals the memory address register. mem_wr_o is high only in an advancing execute phase of a store or a subroutine call. mem_rd_o is high in advancing fetch, indirect, and load or add execute phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Enter run mode and clear halt |
| step_i | input | 1 | Advance one phase in this cycle |
| mem_rdata_i | input | DATA_W | Read data for mem_addr_o, same cycle |
| mem_addr_o | output | DATA_W-1 | Memory address register |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe, taken at the clock edge |
| mem_wdata_o | output | DATA_W | Write data |
| pc_o | output | DATA_W-1 | Program counter |
| acc_a_o | output | DATA_W | Accumulator A |
| acc_b_o | output | DATA_W | Accumulator B |
| fetch_o | output | 1 | Fetch phase indicator |
| indirect_o | output | 1 | Indirect phase indicator |
| execute_o | output | 1 | Execute phase indicator |
| halt_o | output | 1 | Stopped by halt |

## Verification
The bench builds the block with a 16-bit word, a 10-bit page offset and a start address of 2100 octal. This gives five page bits, so the bench can reach a current-page reference that ends exactly at a page limit. It can also reach a page-zero data reference from page one and an indirect hop across into page two. The first program runs under single steps with idle cycles between them, which exposes any advance without a step and any change to the program counter during the first phase of the subroutine call. The second program runs under start and exercises accumulator B, a two-level indirect chain and a direct jump into page zero that ends in halt.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {PH_FETCH, PH_IND, PH_EXEC} phase_e;
  typedef enum logic [2:0] {OP_NOP, OP_HLT, OP_LD, OP_AD, OP_ST, OP_JMP, OP_JSB} op_e;
  typedef struct packed {
    op_e  op;
    logic sel_b;
    logic indir;
    logic cur_page;
  } dec_t;
endpackage

// File: rtl/sq_decode.sv
module sq_decode import sq_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 10
) (
  input  logic [DATA_W-1:0] word_i,
  output dec_t              dec_o,
  output logic [OFS_W-1:0]  ofs_o
);
  localparam logic [DATA_W-1:0] HLT_WORD = (DATA_W'(1) << (DATA_W-1)) | (DATA_W'(1) << OFS_W);

  logic [3:0] opc;
  logic       memref;
  assign opc   = word_i[DATA_W-2 -: 4];
  assign ofs_o = word_i[OFS_W-1:0];

  always_comb begin
    dec_o.op = OP_NOP;
    if (word_i == HLT_WORD) dec_o.op = OP_HLT;
    else begin
      unique case (opc)
        4'b1100, 4'b1101: dec_o.op = OP_LD;
        4'b1000, 4'b1001: dec_o.op = OP_AD;
        4'b1110, 4'b1111: dec_o.op = OP_ST;
        4'b0101:          dec_o.op = OP_JMP;
        4'b0011:          dec_o.op = OP_JSB;
        default:          dec_o.op = OP_NOP;
      endcase
    end
  end

  assign memref         = (dec_o.op != OP_NOP) && (dec_o.op != OP_HLT);
  assign dec_o.indir    = memref & word_i[DATA_W-1];
  assign dec_o.sel_b    = opc[0];
  assign dec_o.cur_page = word_i[OFS_W];
endmodule

// File: rtl/sq_addr_form.sv
module sq_addr_form #(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 10
) (
  input  logic [ADDR_W-OFS_W-1:0] page_i,
  input  logic                    cur_page_i,
  input  logic [OFS_W-1:0]        ofs_i,
  output logic [ADDR_W-1:0]       ea_o
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  assign ea_o = {cur_page_i ? page_i : {PAGE_W{1'b0}}, ofs_i};
endmodule

// File: rtl/phase_seq.sv
module phase_seq import sq_pkg::*; #(
  parameter int                DATA_W   = 16,
  parameter int                OFS_W    = 10,
  parameter logic [DATA_W-2:0] RESET_PC = 15'o2100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-2:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-2:0] pc_o,
  output logic [DATA_W-1:0] acc_a_o,
  output logic [DATA_W-1:0] acc_b_o,
  output logic              fetch_o,
  output logic              indirect_o,
  output logic              execute_o,
  output logic              halt_o
);
  localparam int ADDR_W = DATA_W - 1;

  phase_e              phase_q, ph_d;
  logic [ADDR_W-1:0]   pc_q, pc_d, m_q, m_d, ea, pc_inc, m_inc, ind_addr;
  logic [DATA_W-1:0]   t_q, t_d, a_q, a_d, b_q, b_d, dec_word, acc_sel;
  logic                run_q, run_d, halt_q, halt_d, adv;
  dec_t                dec;
  logic [OFS_W-1:0]    ofs;

  assign dec_word = (phase_q == PH_FETCH) ? mem_rdata_i : t_q;

  sq_decode #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_dec (
    .word_i(dec_word), .dec_o(dec), .ofs_o(ofs)
  );

  sq_addr_form #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_af (
    .page_i(m_q[ADDR_W-1:OFS_W]), .cur_page_i(dec.cur_page), .ofs_i(ofs), .ea_o(ea)
  );

  assign adv      = step_i | run_q;
  assign pc_inc   = pc_q + ADDR_W'(1);
  assign m_inc    = m_q + ADDR_W'(1);
  assign ind_addr = mem_rdata_i[ADDR_W-1:0];
  assign acc_sel  = dec.sel_b ? b_q : a_q;

  always_comb begin
    ph_d   = phase_q;
    pc_d   = pc_q;
    m_d    = m_q;
    t_d    = t_q;
    a_d    = a_q;
    b_d    = b_q;
    run_d  = run_q;
    halt_d = halt_q;
    if (start_i) begin
      run_d  = 1'b1;
      halt_d = 1'b0;
    end
    if (step_i) halt_d = 1'b0;
    if (adv) begin
      unique case (phase_q)
        PH_FETCH: begin
          t_d = mem_rdata_i;
          unique case (dec.op)
            OP_LD, OP_AD, OP_ST, OP_JSB: begin
              m_d  = ea;
              ph_d = dec.indir ? PH_IND : PH_EXEC;
            end
            OP_JMP: begin
              m_d = ea;
              if (dec.indir) ph_d = PH_IND;
              else           pc_d = ea;
            end
            OP_HLT: begin
              pc_d   = pc_inc;
              m_d    = pc_inc;
              run_d  = 1'b0;
              halt_d = 1'b1;
            end
            default: begin
              pc_d = pc_inc;
              m_d  = pc_inc;
            end
          endcase
        end
        PH_IND: begin
          m_d = ind_addr;
          if (!mem_rdata_i[DATA_W-1]) begin
            if (dec.op == OP_JMP) begin
              pc_d = ind_addr;
              ph_d = PH_FETCH;
            end else begin
              ph_d = PH_EXEC;
            end
          end
        end
        PH_EXEC: begin
          ph_d = PH_FETCH;
          pc_d = pc_inc;
          m_d  = pc_inc;
          unique case (dec.op)
            OP_LD: if (dec.sel_b) b_d = mem_rdata_i; else a_d = mem_rdata_i;
            OP_AD: if (dec.sel_b) b_d = b_q + mem_rdata_i; else a_d = a_q + mem_rdata_i;
            OP_JSB: begin
              pc_d = m_inc;
              m_d  = m_inc;
            end
            default: ;
          endcase
        end
        default: ph_d = PH_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
      pc_q    <= RESET_PC;
      m_q     <= RESET_PC;
      t_q     <= '0;
      a_q     <= '0;
      b_q     <= '0;
      run_q   <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      phase_q <= ph_d;
      pc_q    <= pc_d;
      m_q     <= m_d;
      t_q     <= t_d;
      a_q     <= a_d;
      b_q     <= b_d;
      run_q   <= run_d;
      halt_q  <= halt_d;
    end
  end

  assign mem_addr_o  = m_q;
  assign mem_rd_o    = adv & ((phase_q == PH_FETCH) | (phase_q == PH_IND) |
                              ((phase_q == PH_EXEC) & ((dec.op == OP_LD) | (dec.op == OP_AD))));
  assign mem_wr_o    = adv & (phase_q == PH_EXEC) & ((dec.op == OP_ST) | (dec.op == OP_JSB));
  assign mem_wdata_o = (dec.op == OP_JSB) ? {1'b0, pc_inc} : acc_sel;
  assign pc_o        = pc_q;
  assign acc_a_o     = a_q;
  assign acc_b_o     = b_q;
  assign fetch_o     = (phase_q == PH_FETCH);
  assign indirect_o  = (phase_q == PH_IND);
  assign execute_o   = (phase_q == PH_EXEC);
  assign halt_o      = halt_q;

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !run_q) |=> ($stable(pc_q) && $stable(m_q) && $stable(phase_q) && $stable(a_q) && $stable(b_q)));

  assert_ind_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && phase_q == PH_FETCH && dec.indir) |=> (phase_q == PH_IND));

  assert_jmp_direct_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && phase_q == PH_FETCH && dec.op == OP_JMP && !dec.indir) |=> (pc_q == $past(ea) && phase_q == PH_FETCH));

  assert_jsb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && phase_q == PH_FETCH && dec.op == OP_JSB) |=> (pc_q == $past(pc_q)));

  assert_exec_inc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && phase_q == PH_EXEC && dec.op != OP_JSB) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  assert_wr_exec_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (phase_q == PH_EXEC && !mem_rd_o));

  assert_halt_stops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !step_i && !start_i) |=> ($stable(pc_q) && $stable(phase_q)));
endmodule

// File: tb/sim_phase_seq.sv
module sim_phase_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, step_i = 1'b0;
  logic [15:0] rdata, wdata, acc_a, acc_b;
  logic [14:0] maddr, pc;
  logic        rd, wr, f_o, i_o, e_o, halt;

  logic [15:0] mem [4096];
  logic [15:0] mm  [4096];
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  phase_seq #(.DATA_W(16), .OFS_W(10), .RESET_PC(15'o2100)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .step_i(step_i),
    .mem_rdata_i(rdata), .mem_addr_o(maddr), .mem_rd_o(rd), .mem_wr_o(wr),
    .mem_wdata_o(wdata), .pc_o(pc), .acc_a_o(acc_a), .acc_b_o(acc_b),
    .fetch_o(f_o), .indirect_o(i_o), .execute_o(e_o), .halt_o(halt)
  );

  assign rdata = mem[maddr[11:0]];
  always @(posedge clk) if (wr) mem[maddr[11:0]] <= wdata;

  // behavioural reference model
  int mpc, mmar, ma, mb, mph, mt, mop, mea, mw;
  bit mrun, mhalt, madv;

  function automatic int op_of(int w);
    if (w == 'o102000) return 1;
    case ((w >> 11) & 'hF)
      'hC, 'hD: return 2;
      'h8, 'h9: return 3;
      'hE, 'hF: return 4;
      'h5:      return 5;
      'h3:      return 6;
      default:  return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpc = 'o2100; mmar = 'o2100; ma = 0; mb = 0; mph = 0; mt = 0; mrun = 0; mhalt = 0;
    end else begin
      madv = step_i || mrun;
      if (start_i) begin mrun = 1; mhalt = 0; end
      if (step_i) mhalt = 0;
      if (madv) begin
        mw = int'(mm[mmar & 'hFFF]);
        case (mph)
          0: begin
            mt = mw; mop = op_of(mw);
            mea = (((mw >> 10) & 1) != 0 ? (mmar & 'o76000) : 0) | (mw & 'o1777);
            if (mop >= 2 && mop != 5) begin mmar = mea; mph = ((mw >> 15) & 1) != 0 ? 1 : 2; end
            else if (mop == 5) begin
              mmar = mea;
              if (((mw >> 15) & 1) != 0) mph = 1; else mpc = mea;
            end else begin
              mpc = (mpc + 1) & 'o77777; mmar = mpc;
              if (mop == 1) begin mrun = 0; mhalt = 1; end
            end
          end
          1: begin
            mmar = mw & 'o77777;
            if (((mw >> 15) & 1) == 0) begin
              if (op_of(mt) == 5) begin mpc = mmar; mph = 0; end else mph = 2;
            end
          end
          default: begin
            mop = op_of(mt);
            if (mop == 2) begin if (((mt >> 11) & 1) != 0) mb = mw; else ma = mw; end
            if (mop == 3) begin
              if (((mt >> 11) & 1) != 0) mb = (mb + mw) & 'hFFFF; else ma = (ma + mw) & 'hFFFF;
            end
            if (mop == 4) mm[mmar & 'hFFF] = 16'((((mt >> 11) & 1) != 0) ? mb : ma);
            if (mop == 6) begin
              mm[mmar & 'hFFF] = 16'((mpc + 1) & 'o77777);
              mpc = (mmar + 1) & 'o77777; mmar = mpc;
            end else begin
              mpc = (mpc + 1) & 'o77777; mmar = mpc;
            end
            mph = 0;
          end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    int ph;
    int wexp;
    ph = f_o ? 0 : i_o ? 1 : e_o ? 2 : 3;
    wexp = ((step_i || mrun) && mph == 2 && (op_of(mt) == 4 || op_of(mt) == 6)) ? 1 : 0;
    chk("R3 phase", ph, mph);
    chk("R7 pc", int'(pc), mpc);
    chk("R5 mem_addr", int'(maddr), mmar);
    chk("R6 acc_a", int'(acc_a), ma);
    chk("R6 acc_b", int'(acc_b), mb);
    chk("R11 halt", int'(halt), int'(mhalt));
    chk("R12 wr", int'(wr), wexp);
  endtask

  task automatic cyc(input bit st, input bit go);
    @(negedge clk);
    compare_model();
    step_i  = st;
    start_i = go;
  endtask

  task automatic do_step(input string tag, input int eph, input int epc, input int em);
    int ph;
    cyc(1, 0);
    cyc(0, 0);
    ph = f_o ? 0 : i_o ? 1 : e_o ? 2 : 3;
    chk({tag, " phase"}, ph, eph);
    chk({tag, " pc"}, int'(pc), epc);
    chk({tag, " m"}, int'(maddr), em);
    cyc(0, 0);
    chk("R2 idle hold pc", int'(pc), epc);
  endtask

  task automatic poke(input int a, input logic [15:0] v);
    mem[a] = v;
    mm[a]  = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; mm[i] = '0; end
    poke('o2100, 16'o000000); poke('o2101, 16'o026200);
    poke('o2200, 16'o000000); poke('o2201, 16'o000000);
    poke('o2202, 16'o016773); poke('o2203, 16'o102000);
    poke('o2774, 16'o061001); poke('o2775, 16'o143777);
    poke('o2776, 16'o073000); poke('o2777, 16'o126773);
    poke('o3777, 16'o004000); poke('o4000, 16'o000005);
    poke('o1001, 16'o000005);
    poke('o2204, 16'o065001); poke('o2205, 16'o146300);
    poke('o2300, 16'o102301); poke('o2301, 16'o001001);
    poke('o2206, 16'o077001); poke('o2207, 16'o024100);
    poke('o0100, 16'o102000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pc", int'(pc), 'o2100);
    chk("R1 reset fetch", int'(f_o), 1);
    chk("R1 reset acc", int'(acc_a | acc_b), 0);
    chk("R1 reset halt", int'(halt), 0);
    chk("R1 reset no read", int'(rd), 0);
    cyc(0, 0);
    cyc(0, 0);
    chk("R2 no advance pc", int'(pc), 'o2100);

    do_step("R7 nop",        0, 'o2101, 'o2101);
    do_step("R8 jmp direct", 0, 'o2200, 'o2200);
    do_step("R7 nop",        0, 'o2201, 'o2201);
    do_step("R7 nop",        0, 'o2202, 'o2202);
    do_step("R9 jsb ref",    2, 'o2202, 'o2773);
    do_step("R9 jsb exec",   0, 'o2774, 'o2774);
    chk("R9 return word", int'(mem['o2773]), 'o2203);
    do_step("R5 page zero",  2, 'o2774, 'o1001);
    do_step("R6 load a",     0, 'o2775, 'o2775);
    chk("R6 load a value", int'(acc_a), 5);
    do_step("R3 indirect",   1, 'o2775, 'o3777);
    do_step("R4 to exec",    2, 'o2775, 'o4000);
    do_step("R6 add a",      0, 'o2776, 'o2776);
    chk("R6 add a value", int'(acc_a), 10);
    do_step("R5 cur page",   2, 'o2776, 'o3000);
    do_step("R6 store a",    0, 'o2777, 'o2777);
    chk("R6 stored a", int'(mem['o3000]), 10);
    do_step("R3 jmp ind",    1, 'o2777, 'o2773);
    do_step("R10 return",    0, 'o2203, 'o2203);
    do_step("R11 halt",      0, 'o2204, 'o2204);
    chk("R11 halt set", int'(halt), 1);
    cyc(0, 0);
    cyc(0, 0);
    chk("R11 halted hold", int'(pc), 'o2204);

    cyc(0, 1);
    cyc(0, 0);
    chk("R11 start clears", int'(halt), 0);
    for (int i = 0; i < 100; i++) begin
      cyc(0, 0);
      if (halt) break;
    end
    chk("R4 multi-level acc_b", int'(acc_b), 10);
    chk("R6 stored b", int'(mem['o3001]), 10);
    chk("R8 jump page zero then halt pc", int'(pc), 'o0101);
    chk("R11 halt after run", int'(halt), 1);
    chk("R6 acc_a kept", int'(acc_a), 10);
    cyc(0, 0);
    cyc(0, 0);
    chk("R11 run stopped", int'(pc), 'o0101);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule